// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control and address engine of one DMA channel. A peripheral trigger, chosen from a bank of event inputs by a 5-bit code, starts a burst of word moves. Each move is a read from the source address followed by a write to the destination address over a simple request/grant port. Words are counted inside a burst and bursts are counted inside a transfer. Source and destination addresses each advance on three levels: a signed step after every word, a signed step after every burst, and a wrap that rebases the address after a set number of bursts.

Software writes mode settings, sizes, steps and the next transfer's begin addresses through a small register write port. The begin addresses are staged: they are copied into the live address registers only when a new transfer starts, so the next transfer can be prepared while the current one runs. Write-one command bits run, halt, reset and force the channel, and a status vector reports pending flags and progress. A single-cycle interrupt marks either the start or the end of each transfer, and can also mark a trigger overflow. An optional sync event realigns the source or the destination wrap sequence.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is stopped: `status` is all zero, `mem_req` is low and `chan_irq` is low.
- R2: Register 0 bits [4:0] hold the trigger code; code k in 1..29 listens to `trig_in[k-1]` only, and codes 0, 30 and 31 listen to nothing, so no access occurs and the pending flag (status bit 0) stays clear.
- R3: With one-shot mode (register 0 bit 7) clear, each trigger event moves exactly one burst of N words, N being register 2 bits [4:0] plus one, after which the channel waits with status bit 4 (burst busy) clear and status bit 3 (transfer busy) set.
- R4: With one-shot mode set, one trigger moves all M bursts of the transfer back to back, M being register 2 bits [31:16] plus one.
- R5: Register 3 holds the signed per-word steps, register 4 the signed per-burst steps and register 6 the signed wrap steps, source in bits [15:0] and destination in [31:16]; after the last word of a burst the per-burst step is added to that word's address, except that when the side's wrap count (register 5, bursts minus one) runs out the address becomes the wrap base plus the wrap step, which also becomes the new wrap base.
- R6: When the last burst of a transfer ends, the channel stops (status bit 5 clear) if continuous mode (register 0 bit 8) is clear; otherwise it keeps running and the next trigger starts a fresh transfer from the staged begin addresses in registers 7 (source) and 8 (destination).
- R7: With the channel interrupt enable (register 0 bit 12) set, `chan_irq` pulses once per transfer: at its start when register 0 bit 6 is 0, at its end when that bit is 1.
- R8: Register 0 bit 11 selects the word size, shown on `mem_wide`; at 0 only the low 16 bits of the read data are written and the upper bits are zero, at 1 all 32 bits are written.
- R9: With sync enabled (register 0 bit 9), a `sync_in` pulse or the force-sync command (command bit 5) sets the sync flag (status bit 1); the next burst then restarts the source wrap sequence from its wrap base if register 0 bit 10 is 0, or the destination's if it is 1; a sync event while the flag is pending sets the sync error (status bit 2); with sync disabled `sync_in` is ignored.
- R10: A trigger event while the pending flag is already set, and not consumed in that cycle, sets the overflow flag (status bit 6) and pulses `chan_irq` when register 0 bit 5 is set.
- R11: Each word is a read of the source address then a write of the destination address; a request and its address and direction are held until `mem_grant` is high.
- R12: A halt command (command bit 1) stops the channel after the read/write pair in progress, with no further accesses; a later run command (command bit 0) continues the same burst from where it stopped.
- R13: Register 1 takes write-one commands: bit 2 soft reset clears all flags and progress and stops the channel, bit 3 forces a trigger, bit 4 clears the pending and overflow flags, bit 6 clears the sync flag and bit 7 clears the sync error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| trig_in | input | NTRIG | Peripheral trigger events |
| sync_in | input | 1 | Sync event |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_wide | output | 1 | 1 for 32-bit words, 0 for 16-bit |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_grant | input | 1 | Access granted this cycle |
| chan_irq | output | 1 | Channel interrupt pulse |
| status | output | 7 | {overflow, running, burst busy, transfer busy, sync error, sync flag, trigger pending} |

## Verification
The address engine is driven with single-trigger bursts, a one-shot chained transfer that crosses a wrap boundary, and single-word bursts where a sync realigns one side. These separate the per-word step from the per-burst step and the wrap step, and show whether the right side is rebased. Trigger codes are tried at the unused values and with a neighbouring input, which exposes a select that is off by one. Grants that arrive every other cycle, halts in the middle of a burst and soft resets in the middle of a transfer show whether progress is kept or dropped.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NTRIG = 29
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             sync_in,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_wide,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_grant,
  output logic             chan_irq,
  output logic [6:0]       status
);
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {S_STOP, S_WAIT, S_RD, S_WR} st_t;
  st_t st;

  logic [4:0]  m_sel, bsize, wcnt;
  logic        m_ovfie, m_atend, m_oneshot, m_cont, m_syncen, m_syncdst, m_wide, m_chie;
  logic [15:0] tsize, tcnt, s_wsize, d_wsize, s_wcnt, d_wcnt;
  logic [15:0] s_bstep, d_bstep, s_tstep, d_tstep, s_wstep, d_wstep;
  logic [AW-1:0] s_sh, d_sh, s_beg, s_cur, d_beg, d_cur;
  logic [DW-1:0] rbuf;
  logic trig_flag, sync_flag, sync_err, ovf, xact, bact, halt_req, irq_q, trig_hit;

  function automatic logic [AW-1:0] sx(input logic [15:0] v);
    return {{(AW-16){v[15]}}, v};
  endfunction

  wire [7:0] cmd = (cfg_we && cfg_sel == 4'd1) ? cfg_wdata[7:0] : 8'd0;
  wire c_run = cmd[0], c_halt = cmd[1], c_soft = cmd[2], c_ftrig = cmd[3];
  wire c_ctrig = cmd[4], c_fsync = cmd[5], c_csync = cmd[6], c_cerr = cmd[7];

  always_comb begin
    trig_hit = 1'b0;
    for (int i = 0; i < NTRIG; i++)
      if (m_sel == 5'(i + 1)) trig_hit = trig_in[i];
  end

  wire tev       = trig_hit | c_ftrig;
  wire sev       = m_syncen & (sync_in | c_fsync);
  wire halting   = halt_req | c_halt;
  wire start     = (st == S_WAIT) && trig_flag && !halting && !c_soft;
  wire new_xfer  = start && !xact;
  wire sync_use  = start && sync_flag;
  wire pair_done = (st == S_WR) && mem_grant;
  wire last_word = (wcnt == 5'd0);
  wire xfer_done = pair_done && last_word && (tcnt == 16'd0) && !c_soft;
  wire ovf_evt   = tev && trig_flag && !start && !c_ctrig && !c_soft;

  wire s_wrap = (s_wcnt == 16'd0);
  wire d_wrap = (d_wcnt == 16'd0);
  wire [AW-1:0] s_nbeg   = s_wrap ? s_beg + sx(s_wstep) : s_beg;
  wire [AW-1:0] d_nbeg   = d_wrap ? d_beg + sx(d_wstep) : d_beg;
  wire [AW-1:0] s_nburst = s_wrap ? s_nbeg : s_cur + sx(s_tstep);
  wire [AW-1:0] d_nburst = d_wrap ? d_nbeg : d_cur + sx(d_tstep);

  wire irq_nx = (m_chie && ((new_xfer && !m_atend) || (xfer_done && m_atend)))
              || (m_ovfie && ovf_evt);

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? d_cur : s_cur;
  assign mem_wdata = rbuf;
  assign mem_wide  = m_wide;
  assign chan_irq  = irq_q;
  assign status    = {ovf, st != S_STOP, bact, xact, sync_err, sync_flag, trig_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_chie, m_wide, m_syncdst, m_syncen, m_cont, m_oneshot, m_atend, m_ovfie, m_sel} <= '0;
      bsize <= '0; tsize <= '0; s_wsize <= '0; d_wsize <= '0;
      s_bstep <= '0; d_bstep <= '0; s_tstep <= '0; d_tstep <= '0;
      s_wstep <= '0; d_wstep <= '0; s_sh <= '0; d_sh <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        4'd0: {m_chie, m_wide, m_syncdst, m_syncen, m_cont, m_oneshot, m_atend, m_ovfie, m_sel}
                <= cfg_wdata[12:0];
        4'd2: begin bsize <= cfg_wdata[4:0]; tsize <= cfg_wdata[31:16]; end
        4'd3: {d_bstep, s_bstep} <= cfg_wdata;
        4'd4: {d_tstep, s_tstep} <= cfg_wdata;
        4'd5: {d_wsize, s_wsize} <= cfg_wdata;
        4'd6: {d_wstep, s_wstep} <= cfg_wdata;
        4'd7: s_sh <= cfg_wdata[AW-1:0];
        4'd8: d_sh <= cfg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_STOP;
      wcnt <= '0; tcnt <= '0; s_wcnt <= '0; d_wcnt <= '0;
      s_beg <= '0; s_cur <= '0; d_beg <= '0; d_cur <= '0; rbuf <= '0;
      trig_flag <= 1'b0; sync_flag <= 1'b0; sync_err <= 1'b0; ovf <= 1'b0;
      xact <= 1'b0; bact <= 1'b0; halt_req <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= irq_nx;
      if (c_soft) begin
        st <= S_STOP;
        trig_flag <= 1'b0; sync_flag <= 1'b0; sync_err <= 1'b0; ovf <= 1'b0;
        xact <= 1'b0; bact <= 1'b0; halt_req <= 1'b0;
      end else begin
        if (c_ctrig) begin
          trig_flag <= 1'b0; ovf <= 1'b0;
        end else if (tev) begin
          trig_flag <= 1'b1;
          if (ovf_evt) ovf <= 1'b1;
        end else if (start) trig_flag <= 1'b0;

        if (c_csync) sync_flag <= 1'b0;
        else if (sev) begin
          sync_flag <= 1'b1;
          if (sync_flag && !sync_use) sync_err <= 1'b1;
        end else if (sync_use) sync_flag <= 1'b0;
        if (c_cerr) sync_err <= 1'b0;

        if (c_halt) halt_req <= 1'b1;

        case (st)
          S_STOP: if (c_run) begin
            st <= bact ? S_RD : S_WAIT;
            halt_req <= 1'b0;
          end
          S_WAIT: if (halting) begin
            st <= S_STOP; halt_req <= 1'b0;
          end else if (start) begin
            st <= S_RD; bact <= 1'b1; wcnt <= bsize;
            if (!xact) begin
              xact <= 1'b1; tcnt <= tsize; s_wcnt <= s_wsize; d_wcnt <= d_wsize;
              s_beg <= s_sh; s_cur <= s_sh; d_beg <= d_sh; d_cur <= d_sh;
            end else if (sync_flag) begin
              if (m_syncdst) begin d_wcnt <= d_wsize; d_cur <= d_beg; end
              else begin s_wcnt <= s_wsize; s_cur <= s_beg; end
            end
          end
          S_RD: if (mem_grant) begin
            rbuf <= m_wide ? mem_rdata : {{(DW-HW){1'b0}}, mem_rdata[HW-1:0]};
            st <= S_WR;
          end
          S_WR: if (mem_grant) begin
            halt_req <= 1'b0;
            if (!last_word) begin
              wcnt <= wcnt - 5'd1;
              s_cur <= s_cur + sx(s_bstep);
              d_cur <= d_cur + sx(d_bstep);
              st <= halting ? S_STOP : S_RD;
            end else if (tcnt == 16'd0) begin
              bact <= 1'b0; xact <= 1'b0;
              st <= (m_cont && !halting) ? S_WAIT : S_STOP;
            end else begin
              tcnt <= tcnt - 16'd1;
              s_wcnt <= s_wrap ? s_wsize : s_wcnt - 16'd1;
              d_wcnt <= d_wrap ? d_wsize : d_wcnt - 16'd1;
              s_beg <= s_nbeg; s_cur <= s_nburst;
              d_beg <= d_nbeg; d_cur <= d_nburst;
              bact <= m_oneshot;
              if (m_oneshot) wcnt <= bsize;
              st <= halting ? S_STOP : (m_oneshot ? S_RD : S_WAIT);
            end
          end
          default: st <= S_STOP;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_grant,
  input logic [AW-1:0] mem_addr,
  input logic [6:0]    status
);
  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_grant |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_write_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_grant |=> mem_req && mem_we);

  assert_quiet_when_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !status[5] |-> !mem_req);

  assert_overflow_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(status[0]));

  assert_sync_error_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(status[1]));

  assert_burst_inside_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |-> status[3]);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_grant(mem_grant), .mem_addr(mem_addr), .status(status)
);

// File: tb/dma_chan_seq_bench.sv
`timescale 1ns/1ps
module dma_chan_seq_bench;
  localparam int AW = 32, DW = 32, NTRIG = 29;
  localparam logic [31:0] RMASK = 32'h5A5A_A5A5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NTRIG-1:0] trig_in = '0;
  logic sync_in = 1'b0;
  logic mem_req, mem_we, mem_wide, mem_grant, chan_irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [6:0] status;

  logic stall = 1'b0;
  logic [7:0] cyc = '0;
  int n_chk = 0, n_fail = 0, n_log = 0, irq_cnt = 0;
  logic        lg_we   [0:1023];
  logic [31:0] lg_addr [0:1023];
  logic [31:0] lg_data [0:1023];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 8'd1;
  assign mem_grant = mem_req && (!stall || cyc[0]);
  assign mem_rdata = mem_addr ^ RMASK;

  dma_chan_seq #(.AW(AW), .DW(DW), .NTRIG(NTRIG)) u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .trig_in(trig_in), .sync_in(sync_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_grant(mem_grant), .chan_irq(chan_irq), .status(status));

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_grant && n_log < 1024) begin
      lg_we[n_log] <= mem_we; lg_addr[n_log] <= mem_addr; lg_data[n_log] <= mem_wdata;
      n_log <= n_log + 1;
    end
    if (rst_n && chan_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    wreg(4'd1, {24'd0, b});
  endtask

  task automatic trig(input int idx);
    @(negedge clk); trig_in[idx] = 1'b1;
    @(negedge clk); trig_in = '0;
  endtask

  task automatic sync_pulse();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  function automatic logic [31:0] mode(input logic [4:0] sel, input logic ovfie, atend, oneshot,
                                        cont, syncen, syncdst, wide, chie);
    return {19'd0, chie, wide, syncdst, syncen, cont, oneshot, atend, ovfie, sel};
  endfunction

  task automatic setup(input logic [31:0] ssh, dsh, input logic [4:0] bs, input logic [15:0] ts,
                       input logic [31:0] bstep, tstep, wsize, wstep);
    cmd(8'h04);
    wreg(4'd7, ssh); wreg(4'd8, dsh);
    wreg(4'd2, {ts, 11'd0, bs});
    wreg(4'd3, bstep); wreg(4'd4, tstep); wreg(4'd5, wsize); wreg(4'd6, wstep);
  endtask

  task automatic t_reset();
    chk("R1", "status after reset", {25'd0, status}, 32'd0);
    chk("R1", "request after reset", {31'd0, mem_req}, 32'd0);
    chk("R1", "irq after reset", {31'd0, chan_irq}, 32'd0);
  endtask

  task automatic t_trigsel();
    int b;
    setup(32'h1000, 32'h2000, 5'd0, 16'd0, 32'd0, 32'd0, 32'hFFFF_FFFF, 32'd0);
    wreg(4'd0, mode(5'd0, 0, 0, 0, 1, 0, 0, 1, 0));
    cmd(8'h01);
    b = n_log; trig(0); idle(10);
    chk("R2", "code 0 accesses", n_log - b, 0);
    chk("R2", "code 0 pending", {31'd0, status[0]}, 0);
    wreg(4'd0, mode(5'd31, 0, 0, 0, 1, 0, 0, 1, 0));
    b = n_log;
    @(negedge clk); trig_in = '1; @(negedge clk); trig_in = '0;
    idle(10);
    chk("R2", "code 31 accesses", n_log - b, 0);
    wreg(4'd0, mode(5'd5, 0, 0, 0, 1, 0, 0, 1, 0));
    b = n_log; trig(3); idle(10);
    chk("R2", "code 5 neighbour input", n_log - b, 0);
    trig(4); idle(10);
    chk("R2", "code 5 own input", n_log - b, 2);
    wreg(4'd0, mode(5'd29, 0, 0, 0, 1, 0, 0, 1, 0));
    b = n_log; trig(28); idle(10);
    chk("R2", "code 29 input", n_log - b, 2);
  endtask

  task automatic t_burst();
    int b, i0;
    setup(32'h1000, 32'h2000, 5'd3, 16'd2, {16'd2, 16'd1}, {16'd10, 16'd5}, 32'hFFFF_FFFF, 32'd0);
    wreg(4'd0, mode(5'd1, 0, 0, 0, 0, 0, 0, 1, 1));
    cmd(8'h01);
    i0 = irq_cnt;
    b = n_log; trig(0); idle(20);
    chk("R3", "words in burst 1", n_log - b, 8);
    for (int k = 0; k < 4; k++) begin
      chk("R5", "burst 1 read addr", lg_addr[b + 2*k], 32'h1000 + k);
      chk("R5", "burst 1 write addr", lg_addr[b + 2*k + 1], 32'h2000 + 2*k);
    end
    chk("R3", "waiting after burst", {29'd0, status[5:3]}, 32'b101);
    chk("R7", "irq at transfer start", irq_cnt - i0, 1);
    b = n_log; trig(0); idle(20);
    chk("R3", "words in burst 2", n_log - b, 8);
    chk("R5", "burst 2 first read", lg_addr[b], 32'h1008);
    chk("R5", "burst 2 first write", lg_addr[b + 1], 32'h2010);
    b = n_log; cmd(8'h08); idle(20);
    chk("R13", "forced trigger burst", n_log - b, 8);
    chk("R5", "burst 3 last read", lg_addr[b + 6], 32'h1013);
    chk("R5", "burst 3 last write", lg_addr[b + 7], 32'h2026);
    chk("R6", "stopped without continuous", {31'd0, status[5]}, 0);
    chk("R7", "no end irq in start mode", irq_cnt - i0, 1);
  endtask

  task automatic t_oneshot();
    int b, i0;
    logic [31:0] exp_s [0:7];
    exp_s = '{32'h3000, 32'h3001, 32'h3006, 32'h3007, 32'h3100, 32'h3101, 32'h3106, 32'h3107};
    setup(32'h3000, 32'h4000, 5'd1, 16'd3, {16'd1, 16'd1}, {16'd1, 16'd5}, {16'hFFFF, 16'd1}, {16'd0, 16'h0100});
    wreg(4'd0, mode(5'd2, 0, 1, 1, 1, 0, 0, 1, 1));
    cmd(8'h01);
    i0 = irq_cnt;
    b = n_log; trig(1); idle(3);
    chk("R7", "no irq at start in end mode", irq_cnt - i0, 0);
    idle(37);
    chk("R4", "whole transfer from one trigger", n_log - b, 16);
    for (int k = 0; k < 8; k++) begin
      chk("R5", "wrapped read addr", lg_addr[b + 2*k], exp_s[k]);
      chk("R5", "dst addr", lg_addr[b + 2*k + 1], 32'h4000 + k);
    end
    chk("R6", "continuous keeps running", {30'd0, status[5], status[3]}, 32'b10);
    chk("R7", "irq at transfer end", irq_cnt - i0, 1);
    wreg(4'd7, 32'h5000);
    b = n_log; trig(1); idle(40);
    chk("R6", "reload from staged source", lg_addr[b], 32'h5000);
    chk("R6", "reload dst", lg_addr[b + 1], 32'h4000);
    chk("R4", "second transfer size", n_log - b, 16);
  endtask

  task automatic t_width();
    int b;
    setup(32'h7000, 32'h8000, 5'd0, 16'd1, 32'd0, {16'd1, 16'd1}, 32'hFFFF_FFFF, 32'd0);
    wreg(4'd0, mode(5'd3, 0, 0, 0, 0, 0, 0, 0, 0));
    cmd(8'h01);
    chk("R8", "narrow size pin", {31'd0, mem_wide}, 0);
    b = n_log; trig(2); idle(10);
    chk("R8", "narrow write data", lg_data[b + 1], (32'h7000 ^ RMASK) & 32'h0000_FFFF);
    wreg(4'd0, mode(5'd3, 0, 0, 0, 0, 0, 0, 1, 0));
    chk("R8", "wide size pin", {31'd0, mem_wide}, 1);
    b = n_log; trig(2); idle(10);
    chk("R8", "wide write data", lg_data[b + 1], 32'h7001 ^ RMASK);
  endtask

  task automatic t_sync();
    int b;
    setup(32'h6000, 32'h9000, 5'd0, 16'd9, 32'd0, {16'd1, 16'd5}, 32'hFFFF_FFFF, 32'd0);
    wreg(4'd0, mode(5'd4, 0, 0, 0, 0, 1, 0, 1, 0));
    cmd(8'h01);
    trig(3); idle(8); trig(3); idle(8);
    sync_pulse(); idle(1);
    chk("R9", "sync flag set", {31'd0, status[1]}, 1);
    b = n_log; trig(3); idle(8);
    chk("R9", "source realigned", lg_addr[b], 32'h6000);
    chk("R9", "dst untouched", lg_addr[b + 1], 32'h9002);
    chk("R9", "sync flag consumed", {31'd0, status[1]}, 0);
    wreg(4'd0, mode(5'd4, 0, 0, 0, 0, 1, 1, 1, 0));
    sync_pulse();
    b = n_log; trig(3); idle(8);
    chk("R9", "source not realigned", lg_addr[b], 32'h6005);
    chk("R9", "dst realigned", lg_addr[b + 1], 32'h9000);
    sync_pulse(); sync_pulse(); idle(1);
    chk("R9", "sync error", {31'd0, status[2]}, 1);
    cmd(8'h80); idle(1);
    chk("R13", "error cleared flag kept", {30'd0, status[2:1]}, 32'b01);
    cmd(8'h40); idle(1);
    chk("R13", "sync flag cleared", {31'd0, status[1]}, 0);
    cmd(8'h20); idle(1);
    chk("R9", "forced sync", {31'd0, status[1]}, 1);
    cmd(8'h40);
    wreg(4'd0, mode(5'd4, 0, 0, 0, 0, 0, 0, 1, 0));
    sync_pulse(); idle(1);
    chk("R9", "sync ignored when disabled", {31'd0, status[1]}, 0);
  endtask

  task automatic t_overflow();
    int i0;
    cmd(8'h04);
    wreg(4'd0, mode(5'd6, 1, 0, 0, 0, 0, 0, 1, 0));
    i0 = irq_cnt;
    trig(5); idle(1);
    chk("R10", "pending no overflow", {30'd0, status[6], status[0]}, 32'b01);
    trig(5); idle(2);
    chk("R10", "overflow set", {31'd0, status[6]}, 1);
    chk("R10", "overflow irq", irq_cnt - i0, 1);
    cmd(8'h10); idle(1);
    chk("R13", "pending and overflow cleared", {30'd0, status[6], status[0]}, 0);
    wreg(4'd0, mode(5'd6, 0, 0, 0, 0, 0, 0, 1, 0));
    i0 = irq_cnt;
    trig(5); trig(5); idle(2);
    chk("R10", "overflow without irq", {31'd0, status[6]}, 1);
    chk("R10", "irq masked", irq_cnt - i0, 0);
    cmd(8'h10);
  endtask

  task automatic t_handshake();
    int b;
    setup(32'hA000, 32'hB000, 5'd2, 16'd0, {16'd1, 16'd1}, 32'd0, 32'hFFFF_FFFF, 32'd0);
    wreg(4'd0, mode(5'd7, 0, 0, 0, 0, 0, 0, 1, 0));
    stall = 1'b1;
    cmd(8'h01);
    b = n_log; trig(6); idle(40);
    chk("R11", "access count with stalls", n_log - b, 6);
    for (int k = 0; k < 3; k++) begin
      chk("R11", "read then write order", {30'd0, lg_we[b + 2*k], lg_we[b + 2*k + 1]}, 32'b01);
      chk("R11", "stalled read addr", lg_addr[b + 2*k], 32'hA000 + k);
    end
    stall = 1'b0;
  endtask

  task automatic t_halt();
    int b, h;
    setup(32'hC000, 32'hD000, 5'd7, 16'd0, {16'd1, 16'd1}, 32'd0, 32'hFFFF_FFFF, 32'd0);
    wreg(4'd0, mode(5'd8, 0, 0, 0, 0, 0, 0, 1, 0));
    cmd(8'h01);
    b = n_log; trig(7); idle(2);
    cmd(8'h02); idle(6);
    h = n_log - b;
    chk("R12", "halted with burst open", {30'd0, status[5:4]}, 32'b01);
    chk("R12", "halt on pair boundary", h % 2, 0);
    chk("R12", "halt before burst end", (h < 16) ? 1 : 0, 1);
    idle(10);
    chk("R12", "no access while halted", n_log - b, h);
    cmd(8'h01); idle(30);
    chk("R12", "resumed burst complete", n_log - b, 16);
    for (int k = 0; k < 8; k++)
      chk("R12", "contiguous after resume", lg_addr[b + 2*k], 32'hC000 + k);
  endtask

  task automatic t_soft();
    int b;
    setup(32'hC000, 32'hD000, 5'd7, 16'd1, {16'd1, 16'd1}, {16'd1, 16'd1}, 32'hFFFF_FFFF, 32'd0);
    wreg(4'd0, mode(5'd9, 0, 0, 0, 0, 0, 0, 1, 0));
    cmd(8'h01); trig(8); idle(3);
    cmd(8'h04); idle(2);
    chk("R13", "soft reset status", {25'd0, status}, 0);
    chk("R13", "soft reset request", {31'd0, mem_req}, 0);
    cmd(8'h01);
    b = n_log; trig(8); idle(40);
    chk("R13", "fresh transfer after soft reset", lg_addr[b], 32'hC000);
    chk("R13", "burst length after soft reset", n_log - b, 16);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_trigsel();
    t_burst();
    t_oneshot();
    t_width();
    t_sync();
    t_overflow();
    t_handshake();
    t_halt();
    t_soft();
    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule